// File: doc/BRIEF.md
# Three-Level Hardware Page Table Walker

This block resolves a translation miss without software help. Given the virtual page number that missed, a context number and the base of a context table, it fetches the context's root pointer. It then descends through three table levels held in physical memory, issuing one word read at a time over a simple request/valid port. Each word that comes back is classified as a pointer to a further table, a final mapping entry, or an invalid slot.

A walk ends in one of two ways. On success the walker pulses `done` with the mapping entry, the physical page number and the level the mapping was found at; the translation buffer can then be refilled and the access retried. On failure it pulses `fault` with the level where the walk stopped, so the original access can be reported as a page fault. A mapping found above the last level is treated as a large page. In that case the low part of the physical page number is taken from the virtual page number.

Top module: `walk3_top`

## Requirements
- R1: While reset is held and after it is released, `busy`, `memReq`, `done` and `fault` are all low until a request is accepted.
- R2: A request (`reqValid` high) is accepted only when `busy` is low. A request presented while a walk is in progress is ignored: it changes neither the reads issued nor the result of the walk.
- R3: In the cycle after acceptance, `memReq` is high for one cycle with `memAddr` = `ctxBase` + 4 × `reqCtx`, and this read returns the root pointer.
- R4: Bits 1..0 of each returned word give its kind: 00 invalid, 01 pointer, 10 mapping entry, 11 treated as invalid. After a pointer, the next read address is (word with bits 1..0 cleared) + 4 × index. The index is VPN bits 19..12 (virtual address 31..24) after the root, VPN bits 11..6 (VA 23..18) after level 1, and VPN bits 5..0 (VA 17..12) after level 2.
- R5: The walker waits any number of cycles for `memRdValid`. The next `memReq` comes exactly one cycle after the valid cycle. A `memRdValid` that arrives while no walk is in progress has no effect.
- R6: A mapping entry read at level 3 produces a one-cycle `done` one cycle after its valid cycle, with `leafEntry` equal to the word, `physPage` equal to word bits 31..12 and `stopLevel` = 3.
- R7: A mapping entry at level 1 gives `physPage` = {word bits 31..24, VPN bits 11..0} and `stopLevel` = 1. A mapping entry at level 2 gives `physPage` = {word bits 31..18, VPN bits 5..0} and `stopLevel` = 2.
- R8: A root word that is not a pointer faults at level 0. An invalid word at level 1 or 2 faults at that level. A level-3 word that is not a mapping entry (pointer included) faults at level 3. The `fault` pulse comes one cycle after the valid cycle and no further read is issued.
- R9: `busy` is high from the cycle after acceptance up to the cycle in which `done` or `fault` pulses, where it is low. `done` and `fault` are never high together, and each lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Start a walk (taken only when idle) |
| reqVpn | input | 20 | Virtual page number of the missing access |
| reqCtx | input | 8 | Context number indexing the context table |
| ctxBase | input | 32 | Physical byte address of the context table |
| busy | output | 1 | Walk in progress |
| memReq | output | 1 | One-cycle read request |
| memAddr | output | 32 | Byte address of the read |
| memRdValid | input | 1 | Read data valid |
| memRdData | input | 32 | Returned table word |
| done | output | 1 | One-cycle pulse: mapping found |
| fault | output | 1 | One-cycle pulse: page fault |
| stopLevel | output | 2 | Level the walk ended at (0 = context table) |
| leafEntry | output | 32 | Mapping entry word of the last successful walk |
| physPage | output | 20 | Physical page number of the last successful walk |

## Verification
The hardest conditions to reach from the ports are a new request arriving in the middle of a walk, and a read-valid arriving when no read is outstanding. The memory model in the bench therefore has a latency control. A long latency holds the walker in a wait state while the bench pulses `reqValid` with a different context and page, and the bench then confirms that the read addresses and the result are those of the first walk. A separate stray valid is injected while idle, followed by a clean walk. Faults are provoked at every level by placing invalid, reserved-kind and misplaced-pointer words in the tables.

// File: rtl/walk3_pkg.sv
package walk3_pkg;

  typedef enum logic [1:0] {
    ENT_INVALID = 2'b00,
    ENT_PTR     = 2'b01,
    ENT_LEAF    = 2'b10,
    ENT_RSVD    = 2'b11
  } entryKind_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROOT,
    ST_LVL1,
    ST_LVL2,
    ST_LVL3
  } walkState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       start;    // capture request, address the context table
    logic       step;     // follow pointer into table of level stepLvl
    logic [1:0] stepLvl;
    logic       leaf;     // capture mapping entry
    logic       finish;   // record end level
    logic [1:0] endLvl;
  } walkStrobe_t;

endpackage

// File: rtl/walk3_dpath.sv
module walk3_dpath
  import walk3_pkg::*;
#(
  parameter int IDX1_W = 8,
  parameter int IDX2_W = 6,
  parameter int IDX3_W = 6,
  parameter int OFF_W  = 12,
  parameter int CTX_W  = 8
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  walkStrobe_t                            strb,
  input  logic [IDX1_W+IDX2_W+IDX3_W-1:0]        reqVpn,
  input  logic [CTX_W-1:0]                       reqCtx,
  input  logic [IDX1_W+IDX2_W+IDX3_W+OFF_W-1:0]  ctxBase,
  input  logic [IDX1_W+IDX2_W+IDX3_W+OFF_W-1:0]  memRdData,
  output logic [IDX1_W+IDX2_W+IDX3_W+OFF_W-1:0]  memAddr,
  output entryKind_t                             entryKind,
  output logic [IDX1_W+IDX2_W+IDX3_W+OFF_W-1:0]  leafEntry,
  output logic [IDX1_W+IDX2_W+IDX3_W-1:0]        physPage,
  output logic [1:0]                             stopLevel
);
  localparam int PPN_W  = IDX1_W + IDX2_W + IDX3_W;
  localparam int WORD_W = PPN_W + OFF_W;
  localparam logic [PPN_W-1:0] KEEP_L1 = {PPN_W{1'b1}} << (IDX2_W + IDX3_W);
  localparam logic [PPN_W-1:0] KEEP_L2 = {PPN_W{1'b1}} << IDX3_W;
  localparam logic [PPN_W-1:0] KEEP_L3 = {PPN_W{1'b1}};

  logic [PPN_W-1:0]  vpnQ;
  logic [WORD_W-1:0] addrQ;
  logic [WORD_W-1:0] leafQ;
  logic [PPN_W-1:0]  physQ;
  logic [1:0]        stopQ;

  logic [WORD_W-1:0] idxWord;
  logic [WORD_W-1:0] ctxOffset;
  logic [WORD_W-1:0] tableBase;
  logic [PPN_W-1:0]  keepMask;
  logic [PPN_W-1:0]  physNext;

  assign entryKind = entryKind_t'(memRdData[1:0]);
  assign tableBase = {memRdData[WORD_W-1:2], 2'b00};
  assign ctxOffset = {{(WORD_W-CTX_W-2){1'b0}}, reqCtx, 2'b00};

  // table index for the level about to be read, scaled to bytes
  always_comb begin
    case (strb.stepLvl)
      2'd1:    idxWord = {{(WORD_W-IDX1_W-2){1'b0}}, vpnQ[PPN_W-1 -: IDX1_W], 2'b00};
      2'd2:    idxWord = {{(WORD_W-IDX2_W-2){1'b0}}, vpnQ[IDX3_W +: IDX2_W], 2'b00};
      default: idxWord = {{(WORD_W-IDX3_W-2){1'b0}}, vpnQ[0 +: IDX3_W], 2'b00};
    endcase
  end

  // large mappings keep the low page bits from the virtual page number
  always_comb begin
    case (strb.endLvl)
      2'd1:    keepMask = KEEP_L1;
      2'd2:    keepMask = KEEP_L2;
      default: keepMask = KEEP_L3;
    endcase
    physNext = (memRdData[WORD_W-1:OFF_W] & keepMask) | (vpnQ & ~keepMask);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vpnQ  <= '0;
      addrQ <= '0;
      leafQ <= '0;
      physQ <= '0;
      stopQ <= '0;
    end else begin
      if (strb.start) begin
        vpnQ  <= reqVpn;
        addrQ <= ctxBase + ctxOffset;
      end
      if (strb.step) begin
        addrQ <= tableBase + idxWord;
      end
      if (strb.leaf) begin
        leafQ <= memRdData;
        physQ <= physNext;
      end
      if (strb.finish) begin
        stopQ <= strb.endLvl;
      end
    end
  end

  assign memAddr   = addrQ;
  assign leafEntry = leafQ;
  assign physPage  = physQ;
  assign stopLevel = stopQ;

endmodule

// File: rtl/walk3_ctrl.sv
module walk3_ctrl
  import walk3_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        memRdValid,
  input  entryKind_t  entryKind,
  output walkStrobe_t strb,
  output logic        busy,
  output logic        memReq,
  output logic        done,
  output logic        fault
);
  walkState_t state, nextState;
  logic       issue, endDone, endFault;
  logic [1:0] curLvl;

  always_comb begin
    case (state)
      ST_LVL1: curLvl = 2'd1;
      ST_LVL2: curLvl = 2'd2;
      default: curLvl = 2'd3;
    endcase
  end

  always_comb begin
    strb      = '0;
    nextState = state;
    issue     = 1'b0;
    endDone   = 1'b0;
    endFault  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strb.start = 1'b1;
          issue      = 1'b1;
          nextState  = ST_ROOT;
        end
      end
      ST_ROOT: begin
        if (memRdValid) begin
          if (entryKind == ENT_PTR) begin
            strb.step    = 1'b1;
            strb.stepLvl = 2'd1;
            issue        = 1'b1;
            nextState    = ST_LVL1;
          end else begin
            strb.finish = 1'b1;
            strb.endLvl = 2'd0;
            endFault    = 1'b1;
            nextState   = ST_IDLE;
          end
        end
      end
      ST_LVL1, ST_LVL2: begin
        if (memRdValid) begin
          if (entryKind == ENT_PTR) begin
            strb.step    = 1'b1;
            strb.stepLvl = curLvl + 2'd1;
            issue        = 1'b1;
            nextState    = (state == ST_LVL1) ? ST_LVL2 : ST_LVL3;
          end else if (entryKind == ENT_LEAF) begin
            strb.leaf   = 1'b1;
            strb.finish = 1'b1;
            strb.endLvl = curLvl;
            endDone     = 1'b1;
            nextState   = ST_IDLE;
          end else begin
            strb.finish = 1'b1;
            strb.endLvl = curLvl;
            endFault    = 1'b1;
            nextState   = ST_IDLE;
          end
        end
      end
      ST_LVL3: begin
        if (memRdValid) begin
          strb.finish = 1'b1;
          strb.endLvl = 2'd3;
          nextState   = ST_IDLE;
          if (entryKind == ENT_LEAF) begin
            strb.leaf = 1'b1;
            endDone   = 1'b1;
          end else begin
            endFault  = 1'b1;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      memReq <= 1'b0;
      done   <= 1'b0;
      fault  <= 1'b0;
    end else begin
      state  <= nextState;
      memReq <= issue;
      done   <= endDone;
      fault  <= endFault;
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/walk3_top.sv
module walk3_top
  import walk3_pkg::*;
#(
  parameter int IDX1_W = 8,
  parameter int IDX2_W = 6,
  parameter int IDX3_W = 6,
  parameter int OFF_W  = 12,
  parameter int CTX_W  = 8
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  logic                                   reqValid,
  input  logic [IDX1_W+IDX2_W+IDX3_W-1:0]        reqVpn,
  input  logic [CTX_W-1:0]                       reqCtx,
  input  logic [IDX1_W+IDX2_W+IDX3_W+OFF_W-1:0]  ctxBase,
  output logic                                   busy,
  output logic                                   memReq,
  output logic [IDX1_W+IDX2_W+IDX3_W+OFF_W-1:0]  memAddr,
  input  logic                                   memRdValid,
  input  logic [IDX1_W+IDX2_W+IDX3_W+OFF_W-1:0]  memRdData,
  output logic                                   done,
  output logic                                   fault,
  output logic [1:0]                             stopLevel,
  output logic [IDX1_W+IDX2_W+IDX3_W+OFF_W-1:0]  leafEntry,
  output logic [IDX1_W+IDX2_W+IDX3_W-1:0]        physPage
);
  walkStrobe_t strb;
  entryKind_t  entryKind;

  walk3_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .memRdValid (memRdValid),
    .entryKind  (entryKind),
    .strb       (strb),
    .busy       (busy),
    .memReq     (memReq),
    .done       (done),
    .fault      (fault)
  );

  walk3_dpath #(
    .IDX1_W (IDX1_W),
    .IDX2_W (IDX2_W),
    .IDX3_W (IDX3_W),
    .OFF_W  (OFF_W),
    .CTX_W  (CTX_W)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .reqVpn    (reqVpn),
    .reqCtx    (reqCtx),
    .ctxBase   (ctxBase),
    .memRdData (memRdData),
    .memAddr   (memAddr),
    .entryKind (entryKind),
    .leafEntry (leafEntry),
    .physPage  (physPage),
    .stopLevel (stopLevel)
  );

endmodule

// File: rtl/walk3_chk.sv
module walk3_chk (
  input logic       clk,
  input logic       rstN,
  input logic       reqValid,
  input logic       busy,
  input logic       memReq,
  input logic       done,
  input logic       fault,
  input logic [1:0] stopLevel
);
  AST_ACCEPT_STARTS_READ: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy) |=> (busy && memReq)); // R2

  AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq); // R5

  AST_READ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> busy); // R9

  AST_END_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(done && fault)); // R9

  AST_END_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (done || fault) |-> (!busy && $past(busy))); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9

  AST_FAULT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    fault |=> !fault); // R9

  AST_DONE_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (stopLevel != 2'd0)); // R6

  AST_NO_READ_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    (done || fault) |-> !memReq); // R8

endmodule

bind walk3_top walk3_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .busy      (busy),
  .memReq    (memReq),
  .done      (done),
  .fault     (fault),
  .stopLevel (stopLevel)
);

// File: tb/walk3_top_test.sv
`timescale 1ns/1ps
module walk3_top_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [19:0] reqVpn = '0;
  logic [7:0]  reqCtx = '0;
  logic [31:0] ctxBase = 32'h0;
  logic        busy, memReq, done, fault;
  logic [31:0] memAddr, leafEntry;
  logic        memRdValid = 1'b0;
  logic [31:0] memRdData = '0;
  logic [1:0]  stopLevel;
  logic [19:0] physPage;

  walk3_top uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVpn(reqVpn), .reqCtx(reqCtx),
    .ctxBase(ctxBase), .busy(busy), .memReq(memReq), .memAddr(memAddr),
    .memRdValid(memRdValid), .memRdData(memRdData), .done(done), .fault(fault),
    .stopLevel(stopLevel), .leafEntry(leafEntry), .physPage(physPage)
  );

  always #2 clk = ~clk;

  int nChecks = 0;
  int nErrors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // memory model
  logic [31:0] mem [0:2047];
  int          lat = 1;
  int          pend = 0;
  logic [31:0] addrQ = '0;
  bit          spurious = 1'b0;
  int          nReads = 0;
  int          nValid = 0;
  logic [31:0] addrLog [0:7];
  int          reqCyc [0:7];
  int          validLog [0:7];

  always @(negedge clk) begin
    memRdValid = 1'b0;
    if (pend > 0) begin
      pend = pend - 1;
      if (pend == 0) begin
        memRdValid = 1'b1;
        memRdData  = mem[addrQ[12:2]];
        if (nValid < 8) validLog[nValid] = cyc;
        nValid = nValid + 1;
      end
    end
    if (memReq) begin
      addrQ = memAddr;
      pend  = lat;
      if (nReads < 8) begin
        addrLog[nReads] = memAddr;
        reqCyc[nReads]  = cyc;
      end
      nReads = nReads + 1;
    end
    if (spurious) begin
      memRdValid = 1'b1;
      memRdData  = 32'h0000_0402;
    end
  end

  // walk results
  logic        rDone, rFault, rBusyMid, rBusyEnd, rFirstReq, rAfter;
  logic [1:0]  rLvl;
  logic [31:0] rLeaf, rFirstAddr;
  logic [19:0] rPhys;
  int          rEndCyc, rReads, acceptCyc;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [19:0] mkVpn(input logic [7:0] i1, input logic [5:0] i2, input logic [5:0] i3);
    return {i1, i2, i3};
  endfunction

  task automatic setWord(input logic [31:0] addr, input logic [31:0] val);
    mem[addr[12:2]] = val;
  endtask

  // called at a negedge
  task automatic runWalk(input logic [19:0] vpn, input logic [7:0] ctx, input int latency, input bit poke);
    int waitN;
    lat = latency; nReads = 0; nValid = 0;
    reqVpn = vpn; reqCtx = ctx; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    acceptCyc = cyc;
    rFirstReq = memReq; rFirstAddr = memAddr; rBusyMid = busy;
    waitN = 0;
    while (!(done || fault) && waitN < 500) begin
      reqValid = poke && (waitN == 3);
      if (reqValid) begin
        reqVpn = ~vpn;
        reqCtx = ctx + 8'd1;
      end
      @(negedge clk);
      waitN++;
    end
    reqValid = 1'b0;
    rDone = done; rFault = fault; rLvl = stopLevel; rLeaf = leafEntry; rPhys = physPage;
    rBusyEnd = busy; rEndCyc = cyc;
    @(negedge clk);
    rAfter = done | fault | memReq | busy;
    rReads = nReads;
  endtask

  task automatic testReset();
    chk("R1 busy in reset", busy, 0);
    chk("R1 memReq in reset", memReq, 0);
    @(negedge clk); rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 busy after reset", busy, 0);
    chk("R1 memReq after reset", memReq, 0);
    chk("R1 done after reset", done, 0);
    chk("R1 fault after reset", fault, 0);
  endtask

  task automatic testFullWalk(input int latency);
    runWalk(mkVpn(8'h12, 6'h05, 6'h21), 8'd5, latency, 1'b0);
    chk("R3 read issued after accept", rFirstReq, 1);
    chk("R3 root address", rFirstAddr, 32'h14);
    chk("R9 busy after accept", rBusyMid, 1);
    chk("R4 read count", rReads, 4);
    chk("R4 level1 address", addrLog[1], 32'h448);
    chk("R4 level2 address", addrLog[2], 32'h814);
    chk("R4 level3 address", addrLog[3], 32'h984);
    for (int i = 1; i < 4; i++) chk("R5 next read timing", reqCyc[i], validLog[i-1] + 1);
    chk("R6 done", rDone, 1);
    chk("R9 no fault with done", rFault, 0);
    chk("R6 done timing", rEndCyc, validLog[3] + 1);
    chk("R6 level", rLvl, 3);
    chk("R6 entry", rLeaf, 32'hABCD_E002);
    chk("R6 phys page", rPhys, 20'hABCDE);
    chk("R9 busy low at done", rBusyEnd, 0);
    chk("R9 pulse ends, no read after", rAfter, 0);
  endtask

  task automatic testLarge();
    logic [19:0] vpn;
    vpn = mkVpn(8'h30, 6'h2A, 6'h17);
    runWalk(vpn, 8'd5, 2, 1'b0);
    chk("R7 l1 done", rDone, 1);
    chk("R7 l1 level", rLvl, 1);
    chk("R7 l1 reads", rReads, 2);
    chk("R7 l1 phys", rPhys, {8'h5A, vpn[11:0]});
    vpn = mkVpn(8'h13, 6'h3F, 6'h3C);
    runWalk(vpn, 8'd5, 4, 1'b0);
    chk("R7 l2 done", rDone, 1);
    chk("R7 l2 level", rLvl, 2);
    chk("R7 l2 reads", rReads, 3);
    chk("R7 l2 phys", rPhys, {14'(32'h1234_0002 >> 18), vpn[5:0]});
    chk("R7 l2 entry", rLeaf, 32'h1234_0002);
  endtask

  task automatic expectFault(input string tag, input logic [19:0] vpn, input logic [7:0] ctx,
                             input logic [1:0] lvl, input int reads);
    runWalk(vpn, ctx, 3, 1'b0);
    chk({tag, " fault"}, rFault, 1);
    chk({tag, " no done"}, rDone, 0);
    chk({tag, " level"}, rLvl, lvl);
    chk({tag, " reads"}, rReads, reads);
    chk({tag, " timing"}, rEndCyc, validLog[reads-1] + 1);
    chk({tag, " quiet after"}, rAfter, 0);
  endtask

  task automatic testFaults();
    expectFault("R8 root invalid", mkVpn(8'h12, 6'h05, 6'h21), 8'd7, 2'd0, 1);
    expectFault("R8 root not pointer", mkVpn(8'h12, 6'h05, 6'h21), 8'd8, 2'd0, 1);
    expectFault("R8 level1 invalid", mkVpn(8'h40, 6'h00, 6'h00), 8'd5, 2'd1, 2);
    expectFault("R4 R8 level2 kind 11", mkVpn(8'h13, 6'h01, 6'h00), 8'd5, 2'd2, 3);
    expectFault("R8 level3 pointer", mkVpn(8'h12, 6'h06, 6'h02), 8'd5, 2'd3, 4);
    expectFault("R8 level3 invalid", mkVpn(8'h12, 6'h06, 6'h03), 8'd5, 2'd3, 4);
  endtask

  task automatic testBusyRequest();
    runWalk(mkVpn(8'h12, 6'h05, 6'h21), 8'd5, 6, 1'b1);
    chk("R2 reads unchanged", rReads, 4);
    chk("R2 root address unchanged", addrLog[0], 32'h14);
    chk("R2 level3 address unchanged", addrLog[3], 32'h984);
    chk("R2 result unchanged", rPhys, 20'hABCDE);
    chk("R2 done", rDone, 1);
  endtask

  task automatic testStrayValid();
    nReads = 0;
    spurious = 1'b1;
    @(negedge clk);
    spurious = 1'b0;
    @(negedge clk);
    chk("R5 stray valid no done", done, 0);
    chk("R5 stray valid no fault", fault, 0);
    chk("R5 stray valid no busy", busy, 0);
    @(negedge clk);
    chk("R5 stray valid no read", nReads, 0);
    testFullWalk(1);
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) mem[i] = '0;
    setWord(32'h014, 32'h0000_0401);               // ctx 5 root
    setWord(32'h020, 32'h0000_0402);               // ctx 8 root of wrong kind
    setWord(32'h448, 32'h0000_0801);               // L1[0x12]
    setWord(32'h4C0, 32'h5A00_0002);               // L1[0x30] large
    setWord(32'h44C, 32'h0000_0A01);               // L1[0x13]
    setWord(32'h814, 32'h0000_0901);               // L2[0x05]
    setWord(32'h818, 32'h0000_0B01);               // L2[0x06]
    setWord(32'h984, 32'hABCD_E002);               // L3[0x21]
    setWord(32'hAFC, 32'h1234_0002);               // L2b[0x3F] large
    setWord(32'hA04, 32'h0000_0B03);               // L2b[0x01] kind 11
    setWord(32'hB08, 32'h0000_0C01);               // L3b[0x02] pointer
    repeat (3) @(negedge clk);
    testReset();
    testFullWalk(3);
    testFullWalk(7);
    testLarge();
    testFaults();
    testBusyRequest();
    testStrayValid();
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nErrors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule